// File: doc/BRIEF.md
# Q31 Pair Round-Saturate Packer

This datapath unit takes two signed 32-bit Q31 fractions and reduces each one to a signed 16-bit Q15 halfword. Each reduction rounds to the nearest value by adding half a Q15 LSB. When that addition would pass the largest positive value, the lane clamps to the Q15 maximum. The unit then packs the two halfwords into a single 32-bit word.

The first operand fills the upper halfword and the second fills the lower one. A 32-bit control/status register holds a sticky overflow bit at bit 22. Software loads that register through a write port, usually to clear it, and reads it back through a combinational read port. A valid-qualified operation produces the packed result, and any flag change, one clock later.

Top module: `q31_pair_packer`

## Requirements
- R1: The result holds the reduced first operand (`opA`) in bits 31:16 and the reduced second operand (`opB`) in bits 15:0.
- R2: A lane that does not overflow yields bits 31:16 of (input + 0x00008000), taken modulo 2^32. Negative inputs follow the same rule: 0x80000000 gives 0x8000, 0xFFFF8000 gives 0x0000, 0xFFFF7FFF gives 0xFFFF and 0x87657FFF gives 0x8765.
- R3: A lane whose signed input is greater than 0x7FFF7FFF yields 0x7FFF. The input 0x7FFF7FFF itself is not an overflow.
- R4: An operation in which at least one lane overflows sets bit 22 of the control register. An operation with no lane overflow leaves bit 22 unchanged.
- R5: Bit 22 is sticky. Once set, it stays set through later non-overflowing operations until a control register write loads a new value.
- R6: A control register write loads all 32 bits, and `ctrlRdData` returns the register contents on the cycle after the write. Bits other than 22 change only through writes.
- R7: When a write and an overflowing operation occur in the same cycle, the register takes the written value with bit 22 forced to 1. When a write and a non-overflowing operation coincide, the written value is kept as it is.
- R8: `resultValid` is high exactly one cycle after `opValid`, with the matching `result`. `result` holds its value while no operation is issued.
- R9: After reset, `result`, `resultValid` and the control register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Starts a pack operation this cycle |
| opA | input | 32 | First Q31 operand, goes to the upper halfword |
| opB | input | 32 | Second Q31 operand, goes to the lower halfword |
| ctrlWrEn | input | 1 | Loads the control register this cycle |
| ctrlWrData | input | 32 | Value for the control register |
| ctrlRdData | output | 32 | Current control register contents |
| resultValid | output | 1 | Result is new this cycle |
| result | output | 32 | Packed pair of Q15 halfwords |

## Verification
The packing is tried with mixed positive and negative operands, which separates the two lane positions and shows that rounding carries across the halfword. Inputs at 0x7FFF7FFF and 0x7FFF8000 sit on either side of the saturation threshold. They look alike in the result, so only the flag tells them apart. Negative edge values such as 0x80000000, 0xFFFF8000 and 0xFFFF7FFF confirm that the negative side never saturates and that wrap and carry are handled correctly. Overflow in the upper lane only, in the lower lane only, and combined with a same-cycle register write shows that the flag is sticky, which lane raised it, and in what order the write and the flag update are applied.

// File: rtl/q31pk_pkg.sv
package q31pk_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadResult;
  } pkStrobe_t;
endpackage

// File: rtl/q31pk_lane.sv
module q31pk_lane #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic [DATA_W-1:0] laneIn,
  output logic [HALF_W-1:0] laneOut,
  output logic              laneOvf
);
  localparam int SHIFT = DATA_W - HALF_W;
  localparam logic [DATA_W-1:0] ROUND_ADD = DATA_W'(1) << (SHIFT - 1);
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] OVF_LIMIT = MAX_POS - ROUND_ADD;
  localparam logic [HALF_W-1:0] HALF_MAX = {1'b0, {(HALF_W-1){1'b1}}};

  logic [DATA_W-1:0] roundSum;

  always_comb begin
    // Only a positive constant is added, so only the positive side can overflow
    laneOvf  = $signed(laneIn) > $signed(OVF_LIMIT);
    roundSum = laneIn + ROUND_ADD;
    laneOut  = laneOvf ? HALF_MAX : roundSum[DATA_W-1 -: HALF_W];
  end
endmodule

// File: rtl/q31pk_datapath.sv
module q31pk_datapath
  import q31pk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int HALF_W    = 16,
  parameter int NUM_LANES = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  pkStrobe_t                           strobe,
  input  logic [NUM_LANES-1:0][DATA_W-1:0]    laneData,
  output logic                                anyOvf,
  output logic                                resultValid,
  output logic [NUM_LANES*HALF_W-1:0]         result
);
  localparam int RES_W = NUM_LANES * HALF_W;
  localparam logic [HALF_W-1:0] HALF_MAX = {1'b0, {(HALF_W-1){1'b1}}};

  logic [NUM_LANES-1:0]              laneOvf;
  logic [NUM_LANES-1:0][HALF_W-1:0]  laneHalf;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    q31pk_lane #(.DATA_W(DATA_W), .HALF_W(HALF_W)) uLane (
      .laneIn (laneData[g]),
      .laneOut(laneHalf[g]),
      .laneOvf(laneOvf[g])
    );
  end

  assign anyOvf = |laneOvf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      result      <= '0;
    end else begin
      resultValid <= strobe.loadResult;
      if (strobe.loadResult) result <= RES_W'(laneHalf);
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : gChk
    // R3
    lane_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobe.loadResult) && $past(laneOvf[g]) |-> result[g*HALF_W +: HALF_W] == HALF_MAX);
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadResult |=> resultValid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadResult |=> $stable(result) && !resultValid);
endmodule

// File: rtl/q31pk_control.sv
module q31pk_control
  import q31pk_pkg::*;
#(
  parameter int CTRL_W  = 32,
  parameter int OVF_BIT = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              anyOvf,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output pkStrobe_t         strobe,
  output logic [CTRL_W-1:0] ctrlReg
);
  logic              setOvf;
  logic [CTRL_W-1:0] ctrlNext;

  always_comb begin
    strobe.loadResult = opValid;
    setOvf            = opValid && anyOvf;
    // Write applied first, then overflow sets the sticky bit on top
    ctrlNext = ctrlWrEn ? ctrlWrData : ctrlReg;
    if (setOvf) ctrlNext[OVF_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else       ctrlReg <= ctrlNext;
  end

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && anyOvf |=> ctrlReg[OVF_BIT]);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[OVF_BIT] && !ctrlWrEn |=> ctrlReg[OVF_BIT]);

  // R6
  write_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn && !(opValid && anyOvf) |=> ctrlReg == $past(ctrlWrData));

  // R6
  no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrEn && !(opValid && anyOvf) |=> $stable(ctrlReg));
endmodule

// File: rtl/q31_pair_packer.sv
module q31_pair_packer
  import q31pk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HALF_W  = 16,
  parameter int CTRL_W  = 32,
  parameter int OVF_BIT = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  output logic              resultValid,
  output logic [2*HALF_W-1:0] result
);
  localparam int NUM_LANES = 2;

  pkStrobe_t                         strobe;
  logic                              anyOvf;
  logic [NUM_LANES-1:0][DATA_W-1:0]  laneData;

  // Lane 1 (upper halfword) takes the first operand
  assign laneData = {opA, opB};

  q31pk_control #(.CTRL_W(CTRL_W), .OVF_BIT(OVF_BIT)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .anyOvf    (anyOvf),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrData(ctrlWrData),
    .strobe    (strobe),
    .ctrlReg   (ctrlRdData)
  );

  q31pk_datapath #(.DATA_W(DATA_W), .HALF_W(HALF_W), .NUM_LANES(NUM_LANES)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .laneData   (laneData),
    .anyOvf     (anyOvf),
    .resultValid(resultValid),
    .result     (result)
  );
endmodule

// File: tb/q31_pair_packer_test.sv
module q31_pair_packer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        ctrlWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic [31:0] ctrlRdData;
  logic        resultValid;
  logic [31:0] result;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  logic [31:0] ctrlQ[$];
  string       tagQ[$];
  logic [31:0] modelCtrl = '0;
  logic [31:0] lastRes = '0;

  always #2 clk = ~clk;

  q31_pair_packer uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opA(opA), .opB(opB),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .resultValid(resultValid), .result(result)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Reference from requirement text: saturate above 0x7FFF7FFF, else upper half of a+0x8000
  function automatic logic [16:0] refLane(logic [31:0] a);
    logic [31:0] s;
    if ($signed(a) > $signed(32'h7FFF7FFF)) return {1'b1, 16'h7FFF};
    s = a + 32'h0000_8000;
    return {1'b0, s[31:16]};
  endfunction

  task automatic doOp(logic [31:0] a, logic [31:0] b, bit wr, logic [31:0] wd, string tag);
    logic [16:0] hA, hB;
    @(negedge clk);
    opValid = 1'b1; opA = a; opB = b;
    ctrlWrEn = wr; ctrlWrData = wd;
    hA = refLane(a); hB = refLane(b);
    if (wr) modelCtrl = wd;
    if (hA[16] || hB[16]) modelCtrl[22] = 1'b1;
    lastRes = {hA[15:0], hB[15:0]};
    expQ.push_back(lastRes);
    ctrlQ.push_back(modelCtrl);
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 1'b0; ctrlWrEn = 1'b0;
  endtask

  task automatic wrCtrl(logic [31:0] wd);
    @(negedge clk);
    opValid = 1'b0; ctrlWrEn = 1'b1; ctrlWrData = wd;
    modelCtrl = wd;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    check("R6 write readback", ctrlRdData, modelCtrl);
  endtask

  // Monitor: compare each produced result with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && resultValid) begin
        if (expQ.size() == 0) begin
          check("R8 unexpected resultValid", 32'd1, 32'd0);
        end else begin
          string t;
          logic [31:0] e, c;
          e = expQ.pop_front(); c = ctrlQ.pop_front(); t = tagQ.pop_front();
          check(t, result, e);
          check({t, " ctrl"}, ctrlRdData, c);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 result", result, 32'h0);
    check("R9 resultValid", {31'b0, resultValid}, 32'h0);
    check("R9 ctrl", ctrlRdData, 32'h0);
    rstN = 1'b1;

    wrCtrl(32'h1234_5678);                                     // R6 bit 22 clear
    doOp(32'h1234_5678, 32'h8765_7FFF, 0, 0, "R1 R2 mixed pack");
    idle();
    check("R6 other bits kept", ctrlRdData, 32'h1234_5678);
    wrCtrl(32'h0);
    doOp(32'h7FFF_C678, 32'h8654_32A0, 0, 0, "R3 R4 upper lane sat");
    doOp(32'h0000_0000, 32'h0001_0000, 0, 0, "R5 sticky after clean op");
    wrCtrl(32'h0);
    doOp(32'hBEEF_FEED, 32'h7FFF_8000, 0, 0, "R3 R4 lower lane sat");
    wrCtrl(32'h0);
    doOp(32'h7FFF_7FFF, 32'h8000_0000, 0, 0, "R3 boundary no ovf R2 most negative");
    doOp(32'hFFFF_8000, 32'hFFFF_7FFF, 0, 0, "R2 negative carry and wrap");
    doOp(32'h7FFF_FFFF, 32'h0000_0000, 1, 32'h0000_0000, "R7 write with ovf");
    doOp(32'h0123_4567, 32'h89AB_CDEF, 1, 32'hC0FF_EE00, "R7 write with clean op");
    doOp(32'h0000_7FFF, 32'h0000_8000, 0, 0, "R2 half LSB round");
    idle();
    idle();
    // R8 hold while idle
    check("R8 result hold", result, lastRes);
    check("R8 valid low", {31'b0, resultValid}, 32'h0);
    check("R8 queue drained", expQ.size(), 32'd0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule